// File: doc/BRIEF.md
# Burst Address Sequencer with Order Select

This block produces the word address for a four-beat burst into a synchronous memory. A burst starts when one of two active-low address strobes captures a starting address. The first beat uses that address. The next three beats use addresses that the block generates by changing only the two least-significant bits. The upper bits stay as captured for the whole burst.

The controller-side strobe loads the address on its own. The processor-side strobe loads it only while the active-low chip enable is also asserted. The counter steps only on edges where the active-low advance input is low, and it holds while that input is high. A static order pin selects how the two low bits wrap. In linear order they add the beat count modulo 4. In interleaved order they are XORed with the beat count.

The block drives the full internal address and the 2-bit beat index. Both come from registers, so each reflects the edge just before it.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_n is low, addr_out and beat are 0.
- R2: On a rising edge where ld_ctl_n is low, the base register takes addr_in and beat becomes 0, whatever the level of ce_n.
- R3: On a rising edge where ld_cpu_n and ce_n are both low, the base register takes addr_in and beat becomes 0.
- R4: When ld_cpu_n is low while ce_n is high, nothing is loaded. If ld_ctl_n and adv_n are both high, addr_out and beat stay unchanged.
- R5: On a rising edge with no load and adv_n low, beat steps by 1 modulo 4 (0,1,2,3,0).
- R6: On a rising edge with no load and adv_n high, beat and addr_out do not change.
- R7: While ilv_mode is 0 (linear), addr_out[1:0] equals (base[1:0] + beat) mod 4. For example, base 1 gives 1,2,3,0.
- R8: While ilv_mode is 1 (interleaved), addr_out[1:0] equals base[1:0] XOR beat. For example, base 1 gives 1,0,3,2.
- R9: addr_out[AW-1:2] always equals the upper bits of the most recently loaded address.
- R10: A load on the same edge as adv_n low takes priority. It also applies in the middle of a burst: the new address is taken and beat returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_ctl_n | input | 1 | Controller-side load strobe, active low, not gated |
| ld_cpu_n | input | 1 | Processor-side load strobe, active low, gated by ce_n |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Burst advance, active low |
| ilv_mode | input | 1 | Order select: 1 interleaved, 0 linear (static) |
| addr_in | input | AW | Starting address presented with a strobe |
| addr_out | output | AW | Current burst word address |
| beat | output | 2 | Beat index within the burst |

## Verification
The assertions treat ilv_mode as static. The order checks therefore skip any cycle in which the pin differs from its value at the previous edge. In the stimulus, ilv_mode changes only in the cycle before a fresh load, never in the middle of a burst. The properties also treat the strobes, advance and chip enable as clean synchronous levels. The bench drives every input one time unit after a rising edge, so each input is stable across the next sampling edge.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  localparam int BEAT_W = 2;
  typedef logic [BEAT_W-1:0] beat_t;

  // Linear wrap: add the beat count, drop the carry
  function automatic beat_t low_linear(input beat_t start, input beat_t cnt);
    beat_t sum;
    sum = start + cnt;
    return sum;
  endfunction

  // Interleaved wrap: flip start bits by the beat count
  function automatic beat_t low_interleave(input beat_t start, input beat_t cnt);
    return start ^ cnt;
  endfunction

  // Load condition: controller strobe alone, or processor strobe with enable
  function automatic logic load_req(input logic ctl_n, input logic cpu_n,
                                    input logic ce_n);
    return (!ctl_n) || (!cpu_n && !ce_n);
  endfunction
endpackage

// File: rtl/bseq_load_dec.sv
module bseq_load_dec (
  input  logic ld_ctl_n,
  input  logic ld_cpu_n,
  input  logic ce_n,
  input  logic adv_n,
  output logic load_evt,
  output logic step_evt
);
  import bseq_pkg::*;

  always_comb begin
    load_evt = load_req(ld_ctl_n, ld_cpu_n, ce_n);
    // a load always wins over an advance
    step_evt = !load_evt && !adv_n;
  end
endmodule

// File: rtl/bseq_counter.sv
module bseq_counter #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] ONE = CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (step)  cnt <= cnt + ONE;
  end
endmodule

// File: rtl/bseq_base_reg.sv
module bseq_base_reg #(
  parameter int AW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] d,
  output logic [AW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/bseq_order_map.sv
module bseq_order_map (
  input  logic       ilv_mode,
  input  logic [1:0] start,
  input  logic [1:0] cnt,
  output logic [1:0] low
);
  import bseq_pkg::*;

  logic [1:0] lin_low;
  logic [1:0] ilv_low;

  always_comb begin
    lin_low = low_linear(start, cnt);
    ilv_low = low_interleave(start, cnt);
    low     = ilv_mode ? ilv_low : lin_low;
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int AW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_ctl_n,
  input  logic          ld_cpu_n,
  input  logic          ce_n,
  input  logic          adv_n,
  input  logic          ilv_mode,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_out,
  output logic [1:0]    beat
);
  import bseq_pkg::*;

  localparam int LOW_W = BEAT_W;
  localparam int UP_W  = AW - LOW_W;

  logic          load_evt;
  logic          step_evt;
  logic [AW-1:0] base_q;
  logic [1:0]    low_bits;

  bseq_load_dec u_dec (
    .ld_ctl_n (ld_ctl_n),
    .ld_cpu_n (ld_cpu_n),
    .ce_n     (ce_n),
    .adv_n    (adv_n),
    .load_evt (load_evt),
    .step_evt (step_evt)
  );

  bseq_base_reg #(.AW(AW)) u_base (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load_evt),
    .d     (addr_in),
    .q     (base_q)
  );

  bseq_counter #(.CW(LOW_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (load_evt),
    .step  (step_evt),
    .cnt   (beat)
  );

  bseq_order_map u_map (
    .ilv_mode (ilv_mode),
    .start    (base_q[LOW_W-1:0]),
    .cnt      (beat),
    .low      (low_bits)
  );

  assign addr_out = {base_q[AW-1 -: UP_W], low_bits};
endmodule

// File: rtl/bseq_chk.sv
module bseq_chk #(
  parameter int AW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ld_ctl_n,
  input logic          ld_cpu_n,
  input logic          ce_n,
  input logic          adv_n,
  input logic          ilv_mode,
  input logic [AW-1:0] addr_in,
  input logic [AW-1:0] addr_out,
  input logic [1:0]    beat,
  input logic          load_evt,
  input logic          step_evt
);
  AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |-> (addr_out == '0 && beat == 2'd0)); // R1

  AST_CTL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_ctl_n |=> (beat == 2'd0 && addr_out[AW-1:2] == $past(addr_in[AW-1:2]))); // R2

  AST_CPU_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_cpu_n && !ce_n) |=> (beat == 2'd0 && addr_out[AW-1:2] == $past(addr_in[AW-1:2]))); // R3

  AST_CPU_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_ctl_n && !ld_cpu_n && ce_n && adv_n) |=> ($stable(beat) && $stable(addr_out[AW-1:2]))); // R4

  AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> beat == 2'($past(beat) + 2'd1)); // R5

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_evt && adv_n) |=> ($stable(beat) && (ilv_mode != $past(ilv_mode) || $stable(addr_out)))); // R6

  AST_LIN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_evt && !ilv_mode) |=> (ilv_mode != $past(ilv_mode) ||
      2'(addr_out[1:0] - beat) == 2'($past(addr_out[1:0]) - $past(beat)))); // R7

  AST_ILV_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_evt && ilv_mode) |=> (ilv_mode != $past(ilv_mode) ||
      (addr_out[1:0] ^ beat) == ($past(addr_out[1:0]) ^ $past(beat)))); // R8

  AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(addr_out[AW-1:2])); // R9

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !adv_n) |=> beat == 2'd0); // R10
endmodule

bind burst_addr_seq bseq_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ld_ctl_n (ld_ctl_n),
  .ld_cpu_n (ld_cpu_n),
  .ce_n     (ce_n),
  .adv_n    (adv_n),
  .ilv_mode (ilv_mode),
  .addr_in  (addr_in),
  .addr_out (addr_out),
  .beat     (beat),
  .load_evt (load_evt),
  .step_evt (step_evt)
);

// File: tb/sim_burst_addr_seq.sv
`timescale 1ns/1ps
module sim_burst_addr_seq;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_ctl_n = 1'b1;
  logic          ld_cpu_n = 1'b1;
  logic          ce_n = 1'b1;
  logic          adv_n = 1'b1;
  logic          ilv_mode = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic [1:0]    beat;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  burst_addr_seq #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .ld_ctl_n(ld_ctl_n), .ld_cpu_n(ld_cpu_n),
    .ce_n(ce_n), .adv_n(adv_n), .ilv_mode(ilv_mode), .addr_in(addr_in),
    .addr_out(addr_out), .beat(beat)
  );

  // expected low bits, written from the order rules
  function automatic logic [1:0] want_low(input logic [1:0] s, input int k, input bit ilv);
    int v;
    if (ilv) return s ^ 2'(k);
    v = (int'(s) + k) % 4;
    return 2'(v);
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [AW-1:0] exp_a, input logic [1:0] exp_b);
    total++;
    if (addr_out !== exp_a || beat !== exp_b) begin
      bad++;
      $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
               req, addr_out, beat, exp_a, exp_b);
    end
  endtask

  task automatic idle();
    ld_ctl_n = 1'b1; ld_cpu_n = 1'b1; ce_n = 1'b1; adv_n = 1'b1;
  endtask

  task automatic t_reset();
    check("R1", '0, 2'd0);
    tick();
    check("R1", '0, 2'd0);
    rst_n = 1'b1;
    tick();
  endtask

  task automatic t_ctl_load(input logic [AW-1:0] a);
    idle(); ld_ctl_n = 1'b0; ce_n = 1'b1; addr_in = a;
    tick(); idle();
    check("R2", a, 2'd0);
  endtask

  task automatic t_cpu_load(input logic [AW-1:0] a);
    idle(); ld_cpu_n = 1'b0; ce_n = 1'b0; addr_in = a;
    tick(); idle();
    check("R3", a, 2'd0);
  endtask

  task automatic t_cpu_gated(input logic [AW-1:0] held, input logic [1:0] hb);
    idle(); ld_cpu_n = 1'b0; ce_n = 1'b1; addr_in = ~held;
    tick(); tick(); idle();
    check("R4", held, hb);
  endtask

  // full burst with advance held low, checked each beat and past the wrap
  task automatic t_burst(input logic [AW-1:0] a, input bit ilv, input string req);
    ilv_mode = ilv;
    t_ctl_load(a);
    for (int k = 1; k <= 5; k++) begin
      adv_n = 1'b0;
      tick();
      check(req, {a[AW-1:2], want_low(a[1:0], k % 4, ilv)}, 2'(k % 4));
      check("R9", {a[AW-1:2], want_low(a[1:0], k % 4, ilv)}, 2'(k % 4));
    end
    adv_n = 1'b1;
  endtask

  task automatic t_hold(input logic [AW-1:0] a);
    logic [AW-1:0] e;
    ilv_mode = 1'b0;
    t_cpu_load(a);
    adv_n = 1'b0; tick(); adv_n = 1'b1;
    e = {a[AW-1:2], want_low(a[1:0], 1, 1'b0)};
    check("R5", e, 2'd1);
    tick(); tick(); tick();
    check("R6", e, 2'd1);
    t_cpu_gated(e, 2'd1);
  endtask

  task automatic t_reload(input logic [AW-1:0] a, input logic [AW-1:0] b);
    ilv_mode = 1'b1;
    t_ctl_load(a);
    adv_n = 1'b0; tick(); tick();
    check("R8", {a[AW-1:2], a[1:0] ^ 2'd2}, 2'd2);
    ld_cpu_n = 1'b0; ce_n = 1'b0; addr_in = b;
    tick(); idle();
    check("R10", b, 2'd0);
    adv_n = 1'b0; tick(); adv_n = 1'b1;
    check("R10", {b[AW-1:2], b[1:0] ^ 2'd1}, 2'd1);
  endtask

  initial begin
    t_reset();
    t_ctl_load(18'h2A5F1);
    t_cpu_load(18'h10002);
    t_cpu_gated(18'h10002, 2'd0);
    t_burst(18'h3C001, 1'b0, "R7");
    t_burst(18'h05553, 1'b0, "R7");
    t_burst(18'h3C001, 1'b1, "R8");
    t_burst(18'h12342, 1'b1, "R8");
    t_hold(18'h0ABC1);
    t_reload(18'h22223, 18'h31110);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule